// File: doc/BRIEF.md
# Pointer-register address generator

This unit forms data-memory addresses for indirect loads and stores that go through one of three 16-bit pointers. Each pointer is a pair of 8-bit registers: pointer 0 is register 27 (high byte) over register 26 (low byte), pointer 1 is 29:28 and pointer 2 is 31:30. An 8-bit page register per pointer sits above the 16 pointer bits, so the address reaches a 24-bit data space. The register file supplies the current pair and page values. The decoder supplies a pointer select, an addressing mode and a 6-bit unsigned displacement.

Each access occupies two cycles. In the first cycle the unit presents the effective address, or it raises an illegal-mode flag when the request cannot be served. In the second cycle it returns the updated pointer with a write-back strobe, but only when the mode changes the pointer. A request that arrives in the second cycle of an access is accepted at once. If it uses the pointer that is being written back in that cycle, the unit takes the written-back value in place of the stale register-file contents.

Top module: `ptrgen_top`

## Requirements
- R1: While reset is high and in the cycle after it, `addr_valid`, `illegal` and `wb_valid` are 0 and `ready` is 1.
- R2: `ptr_sel` 0, 1 and 2 select bits [15:0], [31:16] and [47:32] of `ptr_bus` and bytes [7:0], [15:8] and [23:16] of `page_bus`. Within a pointer slice, the upper byte is the higher-numbered register. The address is {page, 16-bit value}.
- R3: Mode 0 (plain) addresses {page, pointer} and produces no write-back.
- R4: Mode 1 (post-increment) addresses {page, pointer} and writes back pointer+1.
- R5: Mode 2 (pre-decrement) addresses {page, pointer-1} and writes back pointer-1.
- R6: Mode 3 (displacement) on pointer 1 or 2 addresses {page, pointer+disp}, where disp is unsigned 0..63, and produces no write-back.
- R7: Mode 3 on pointer 0, or any mode with `ptr_sel`=3, pulses `illegal` for one cycle. It gives no `addr_valid` and no write-back.
- R8: A request is accepted at a rising edge where `req` and `ready` are both 1. `addr_valid` or `illegal` is high for exactly the next cycle, during which `ready` is 0 and `req` is ignored. Any write-back follows in the cycle after that.
- R9: A request accepted while `wb_valid` is high and `wb_sel` equals `ptr_sel` uses `wb_ptr` as its pointer value instead of `ptr_bus`.
- R10: Increment, decrement and displacement wrap modulo 2^16. The page byte of the address is never carried into or borrowed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request |
| ptr_sel | input | 2 | Pointer select (0, 1, 2; 3 is illegal) |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ptr_bus | input | 48 | Current pointer values from the register file |
| page_bus | input | 24 | Page registers, one byte per pointer |
| ready | output | 1 | Request can be accepted at the next edge |
| addr_valid | output | 1 | Effective address valid |
| addr | output | 24 | Effective data address |
| illegal | output | 1 | Illegal mode/select pulse |
| wb_valid | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer being written back |
| wb_ptr | output | 16 | Updated pointer value |

## Verification
The write-back of one access and the acceptance of the next request share a cycle, because an access's second cycle is also the acceptance window for the next request. The bench holds `req` high so that accesses run back to back through the same pointer. Its register-file model applies `wb_ptr` only at the clock edge, so the design sees the stale value unless it forwards. The scoreboard's architectural pointer model predicts each address, and a wrong or missing forward shows up as an address off by one step.

// File: rtl/ptrgen_pkg.sv
package ptrgen_pkg;
  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_WB   = 2'd2
  } phase_e;
endpackage

// File: rtl/ptrgen_operand_sel.sv
module ptrgen_operand_sel #(
  parameter int NPTR = 3,
  parameter int PW   = 16,
  parameter int EW   = 8,
  parameter int SW   = 2,
  parameter logic [NPTR-1:0] DISP_MASK = 3'b110
) (
  input  logic [NPTR*PW-1:0] ptr_bus,
  input  logic [NPTR*EW-1:0] page_bus,
  input  logic [SW-1:0]      sel,
  input  logic               fwd_valid,
  input  logic [SW-1:0]      fwd_sel,
  input  logic [PW-1:0]      fwd_ptr,
  output logic [PW-1:0]      ptr_o,
  output logic [EW-1:0]      page_o,
  output logic               sel_ok,
  output logic               disp_ok
);
  logic [PW-1:0] ptrs  [NPTR];
  logic [EW-1:0] pages [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_unpack
    assign ptrs[i]  = ptr_bus[i*PW +: PW];
    assign pages[i] = page_bus[i*EW +: EW];
  end

  always_comb begin
    ptr_o   = '0;
    page_o  = '0;
    sel_ok  = 1'b0;
    disp_ok = 1'b0;
    for (int i = 0; i < NPTR; i++) begin
      if (sel == SW'(i)) begin
        ptr_o   = ptrs[i];
        page_o  = pages[i];
        sel_ok  = 1'b1;
        disp_ok = DISP_MASK[i];
      end
    end
    // bypass a write-back that the register file has not absorbed yet
    if (sel_ok && fwd_valid && (fwd_sel == sel))
      ptr_o = fwd_ptr;
  end
endmodule

// File: rtl/ptrgen_addr_calc.sv
module ptrgen_addr_calc
  import ptrgen_pkg::*;
#(
  parameter int PW = 16,
  parameter int EW = 8,
  parameter int DW = 6
) (
  input  logic [PW-1:0]    ptr,
  input  logic [EW-1:0]    page,
  input  amode_e           mode,
  input  logic [DW-1:0]    disp,
  input  logic             sel_ok,
  input  logic             disp_ok,
  output logic [EW+PW-1:0] addr,
  output logic [PW-1:0]    upd_ptr,
  output logic             wb_req,
  output logic             illegal
);
  logic [PW-1:0] inc_v, dec_v, sum_v;

  assign inc_v = ptr + PW'(1);
  assign dec_v = ptr - PW'(1);
  assign sum_v = ptr + PW'(disp);

  always_comb begin
    illegal = !sel_ok || ((mode == AM_DISP) && !disp_ok);
    addr    = {page, ptr};
    upd_ptr = ptr;
    wb_req  = 1'b0;
    unique case (mode)
      AM_PLAIN: ;
      AM_POSTINC: begin
        upd_ptr = inc_v;
        wb_req  = 1'b1;
      end
      AM_PREDEC: begin
        addr    = {page, dec_v};
        upd_ptr = dec_v;
        wb_req  = 1'b1;
      end
      AM_DISP: addr = {page, sum_v};
      default: ;
    endcase
    if (illegal) wb_req = 1'b0;
  end
endmodule

// File: rtl/ptrgen_seq.sv
module ptrgen_seq
  import ptrgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic ready,
  output logic load,
  output logic in_addr
);
  phase_e ph_q;

  assign ready   = (ph_q != PH_ADDR);
  assign load    = req && ready;
  assign in_addr = (ph_q == PH_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           ph_q <= PH_IDLE;
    else if (in_addr)  ph_q <= PH_WB;
    else if (load)     ph_q <= PH_ADDR;
    else               ph_q <= PH_IDLE;
  end
endmodule

// File: rtl/ptrgen_top.sv
module ptrgen_top
  import ptrgen_pkg::*;
#(
  parameter int NPTR = 3,
  parameter int PW   = 16,
  parameter int EW   = 8,
  parameter int DW   = 6,
  parameter int SW   = 2,
  parameter logic [NPTR-1:0] DISP_MASK = 3'b110
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [SW-1:0]        ptr_sel,
  input  logic [1:0]           mode,
  input  logic [DW-1:0]        disp,
  input  logic [NPTR*PW-1:0]   ptr_bus,
  input  logic [NPTR*EW-1:0]   page_bus,
  output logic                 ready,
  output logic                 addr_valid,
  output logic [EW+PW-1:0]     addr,
  output logic                 illegal,
  output logic                 wb_valid,
  output logic [SW-1:0]        wb_sel,
  output logic [PW-1:0]        wb_ptr
);
  localparam int AW = EW + PW;

  logic          load, in_addr;
  logic [PW-1:0] cur_ptr, upd_ptr;
  logic [EW-1:0] cur_page;
  logic          sel_ok, disp_ok, wb_req, ill_c;
  logic [AW-1:0] addr_c;

  logic          av_q, ill_q, wbp_q, wbv_q;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] upd_q, wbptr_q;
  logic [SW-1:0] sel_q, wbsel_q;

  ptrgen_seq u_seq (
    .clk(clk), .rst(rst), .req(req),
    .ready(ready), .load(load), .in_addr(in_addr)
  );

  ptrgen_operand_sel #(
    .NPTR(NPTR), .PW(PW), .EW(EW), .SW(SW), .DISP_MASK(DISP_MASK)
  ) u_opsel (
    .ptr_bus(ptr_bus), .page_bus(page_bus), .sel(ptr_sel),
    .fwd_valid(wbv_q), .fwd_sel(wbsel_q), .fwd_ptr(wbptr_q),
    .ptr_o(cur_ptr), .page_o(cur_page), .sel_ok(sel_ok), .disp_ok(disp_ok)
  );

  ptrgen_addr_calc #(.PW(PW), .EW(EW), .DW(DW)) u_calc (
    .ptr(cur_ptr), .page(cur_page), .mode(amode_e'(mode)), .disp(disp),
    .sel_ok(sel_ok), .disp_ok(disp_ok),
    .addr(addr_c), .upd_ptr(upd_ptr), .wb_req(wb_req), .illegal(ill_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      av_q    <= 1'b0;
      ill_q   <= 1'b0;
      wbp_q   <= 1'b0;
      wbv_q   <= 1'b0;
      addr_q  <= '0;
      upd_q   <= '0;
      sel_q   <= '0;
      wbptr_q <= '0;
      wbsel_q <= '0;
    end else begin
      av_q  <= load && !ill_c;
      ill_q <= load && ill_c;
      if (load) begin
        addr_q <= addr_c;
        upd_q  <= upd_ptr;
        sel_q  <= ptr_sel;
        wbp_q  <= wb_req;
      end
      wbv_q <= in_addr && wbp_q;
      if (in_addr) begin
        wbptr_q <= upd_q;
        wbsel_q <= sel_q;
      end
    end
  end

  assign addr_valid = av_q;
  assign addr       = addr_q;
  assign illegal    = ill_q;
  assign wb_valid   = wbv_q;
  assign wb_sel     = wbsel_q;
  assign wb_ptr     = wbptr_q;
endmodule

// File: rtl/ptrgen_chk.sv
module ptrgen_chk #(
  parameter int PW = 16,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic          ready,
  input logic [1:0]    mode,
  input logic          addr_valid,
  input logic [EW+PW-1:0] addr,
  input logic          illegal,
  input logic          wb_valid,
  input logic [PW-1:0] wb_ptr
);
  logic accept;
  assign accept = req && ready;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!addr_valid && !illegal && !wb_valid && ready)); // R1

  AST_ADDR_PULSE: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid); // R8

  AST_BUSY_IN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (addr_valid || illegal) |-> !ready); // R8

  AST_ILL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(addr_valid && illegal)); // R7

  AST_WB_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ($past(accept, 2) && $past(addr_valid))); // R8

  AST_POSTINC_WB: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && $past(mode, 2) == 2'd1) |-> (wb_ptr == PW'($past(addr[PW-1:0]) + PW'(1)))); // R4

  AST_PREDEC_WB: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && $past(mode, 2) == 2'd2) |-> (wb_ptr == $past(addr[PW-1:0]))); // R5
endmodule

bind ptrgen_top ptrgen_chk #(.PW(PW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .ready(ready), .mode(mode),
  .addr_valid(addr_valid), .addr(addr), .illegal(illegal),
  .wb_valid(wb_valid), .wb_ptr(wb_ptr)
);

// File: tb/tb_ptrgen_top.sv
`timescale 1ns/1ps
module tb_ptrgen_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [1:0]  mode = '0;
  logic [5:0]  disp = '0;
  logic [47:0] ptr_bus;
  logic [23:0] page_bus;
  logic        ready, addr_valid, illegal, wb_valid;
  logic [23:0] addr;
  logic [1:0]  wb_sel;
  logic [15:0] wb_ptr;

  always #4 clk = ~clk;

  logic [15:0] rf   [3];
  logic [15:0] arch [3];
  logic [7:0]  pg   [3];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct { bit ill; logic [23:0] a; int c; string tag; } aexp_t;
  typedef struct { logic [1:0] s; logic [15:0] v; int c; string tag; } wexp_t;
  aexp_t aq[$];
  wexp_t wq[$];

  assign ptr_bus  = {rf[2], rf[1], rf[0]};
  assign page_bus = {pg[2], pg[1], pg[0]};

  ptrgen_top dut (
    .clk(clk), .rst(rst), .req(req), .ptr_sel(ptr_sel), .mode(mode), .disp(disp),
    .ptr_bus(ptr_bus), .page_bus(page_bus), .ready(ready), .addr_valid(addr_valid),
    .addr(addr), .illegal(illegal), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_ptr(wb_ptr)
  );

  // register file model: absorbs write-back at the clock edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && wb_valid) rf[wb_sel] <= wb_ptr;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setp(input int s, input logic [15:0] v, input logic [7:0] p);
    rf[s] = v; arch[s] = v; pg[s] = p;
  endtask

  // driver: issues a request and pushes what the scoreboard must see
  task automatic issue(input int s, input int md, input int d, input string tag);
    aexp_t ae;
    wexp_t we;
    logic [15:0] p, np;
    bit ill, wb;
    @(negedge clk);
    req = 1'b1; ptr_sel = 2'(s); mode = 2'(md); disp = 6'(d);
    while (!ready) @(negedge clk);
    @(posedge clk); #1;
    ill = (s > 2) || (md == 3 && s == 0);
    ae.ill = ill; ae.c = cyc; ae.tag = tag; ae.a = '0;
    wb = 1'b0;
    if (!ill) begin
      p = arch[s]; np = p;
      case (md)
        0: ae.a = {pg[s], p};
        1: begin ae.a = {pg[s], p}; np = p + 16'd1; wb = 1'b1; end
        2: begin np = p - 16'd1; ae.a = {pg[s], np}; wb = 1'b1; end
        default: ae.a = {pg[s], 16'(p + 16'(d))};
      endcase
      if (wb) begin
        arch[s] = np;
        we.s = 2'(s); we.v = np; we.c = cyc + 1; we.tag = tag;
        wq.push_back(we);
      end
    end
    aq.push_back(ae);
  endtask

  task automatic idle(input int n);
    @(negedge clk); req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (addr_valid || illegal) begin
        if (aq.size() == 0) chk(0, "R8 unexpected address pulse", 32'(addr), 0);
        else begin
          aexp_t e;
          e = aq.pop_front();
          chk(illegal == e.ill && addr_valid == !e.ill, {e.tag, " kind"},
              {illegal, addr_valid}, {e.ill, !e.ill});
          if (!e.ill) chk(addr == e.a, {e.tag, " address"}, 32'(addr), 32'(e.a));
          chk(cyc == e.c, {e.tag, " R8 address cycle"}, cyc, e.c);
          chk(ready == 1'b0, {e.tag, " R8 busy"}, ready, 0);
        end
      end
      if (wb_valid) begin
        if (wq.size() == 0) chk(0, "R3 R6 R7 unexpected write-back", 32'(wb_ptr), 0);
        else begin
          wexp_t w;
          w = wq.pop_front();
          chk(wb_sel == w.s, {w.tag, " wb select"}, wb_sel, w.s);
          chk(wb_ptr == w.v, {w.tag, " wb value"}, wb_ptr, w.v);
          chk(cyc == w.c, {w.tag, " R8 wb cycle"}, cyc, w.c);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setp(0, 16'h1234, 8'h01);
    setp(1, 16'h8000, 8'h02);
    setp(2, 16'hFFFF, 8'h7F);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready && !addr_valid && !illegal && !wb_valid, "R1 reset outputs",
        {ready, addr_valid, illegal, wb_valid}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(ready && !addr_valid && !illegal && !wb_valid, "R1 after reset",
        {ready, addr_valid, illegal, wb_valid}, 4'b1000);

    issue(0, 0, 5, "R2 R3 plain ptr0");          idle(2);
    issue(1, 0, 0, "R2 R3 plain ptr1");          idle(2);
    issue(1, 3, 63, "R6 disp ptr1 max");         idle(2);
    issue(2, 3, 1, "R6 R10 disp ptr2 wrap");     idle(2);
    issue(0, 3, 7, "R7 disp on ptr0");           idle(2);
    issue(3, 1, 0, "R7 select 3");               idle(2);
    issue(2, 1, 0, "R4 R10 postinc ptr2 wrap");  idle(3);
    issue(2, 0, 0, "R10 R3 page kept ptr2");     idle(2);
    issue(1, 2, 0, "R5 predec ptr1");            idle(3);
    issue(0, 1, 0, "R4 R9 chain ptr0 a");
    issue(0, 1, 0, "R4 R9 chain ptr0 b");
    issue(0, 1, 0, "R4 R9 chain ptr0 c");
    issue(0, 2, 0, "R5 R9 predec after inc");
    issue(0, 0, 0, "R3 R9 plain after dec");
    issue(2, 2, 0, "R5 chain ptr2");
    issue(1, 1, 0, "R4 other pointer no forward");
    issue(1, 3, 2, "R6 R9 disp after inc");
    idle(4);
    setp(0, 16'h0000, 8'hA5);
    issue(0, 2, 0, "R5 R10 predec wrap");
    issue(0, 1, 0, "R4 R9 inc after wrap");
    idle(6);
    chk(aq.size() == 0 && wq.size() == 0, "R8 all results seen",
        aq.size() + wq.size(), 0);
    chk(rf[0] == arch[0] && rf[1] == arch[1] && rf[2] == arch[2], "R9 final pointers",
        32'(rf[0]), 32'(arch[0]));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule